// File: doc/BRIEF.md
# Peak-Current PWM Pulse Controller

This block produces the gate-drive pulse for a fixed-frequency converter that runs in peak-current mode. A digital oscillator counts out each switching cycle from a period word. A slow triangular dither moves the cycle length up and down so that the switching spectrum is spread. At each cycle boundary a driver latch is set. It is cleared later in the cycle by whichever comes first: a current-sense trip, a soft-start trip, the end of a forced minimum on-time, or the duty cap chosen by a static select input.

The analog side is outside the block and arrives as digital comparator flags. These cover the current-sense limit, the soft-start limit, the light-load minimum-on band, and the two skip levels. Light-load skip has hysteresis. It is decided once per cycle at the cycle boundary, so a pulse already under way is never cut short. A cycle-start strobe goes out with the drive so that neighbouring logic can align to the switching frame.

Top module: `pcm_pwm_ctrl`

## Requirements
- R1: While rst_ni is low, drv_o and cyc_start_o are low. When en_i is sampled low at a clock edge, drv_o is low in the following cycle and no new pulse begins.
- R2: Values of period_i below PER_MIN (default 8) are treated as PER_MIN. cyc_start_o is high for exactly one clock per cycle.
- R3: Each cycle lasts P + a clocks. P is the clamped period word. The offset a starts at 0 after reset, moving upwards, and changes by one at every cycle start. It reverses direction on reaching +L or -L, where L = floor(P*51/1024), which is about 5% of P.
- R4: A pulse is enabled by the cycle start. drv_o rises in the clock after the one in which cyc_start_o is high.
- R5: With no earlier termination, the pulse lasts floor(Peff/2) clocks when duty_sel_i=0 and floor(4*Peff/5) clocks when duty_sel_i=1, where Peff is the current cycle length. drv_o is never high while cyc_start_o is high.
- R6: cs_trip_i and ss_trip_i are ignored during the first BLANK_CYC (default 32) clocks of a pulse. A trip held from earlier ends the pulse after exactly BLANK_CYC clocks.
- R7: After blanking, a trip that is first seen in on-clock j of the pulse ends it with j clocks high. Either trip input has this effect.
- R8: If minon_i is high at the cycle start, the pulse lasts exactly min(MIN_ON_CYC, duty cap) clocks (default MIN_ON_CYC 20), and trip inputs are ignored.
- R9: If skip_lo_i is high at the cycle start, that cycle has no pulse. This holds even if skip_hi_i is also high.
- R10: Skip state holds across cycles while both skip inputs are low at the cycle start. Skip is left only when skip_hi_i is high at a cycle start.
- R11: A skip_lo_i assertion that arrives after the cycle start does not shorten the pulse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Drive enable |
| period_i | input | PER_W | Nominal cycle length in clocks |
| duty_sel_i | input | 1 | Duty cap select: 0 gives 50%, 1 gives 80% |
| cs_trip_i | input | 1 | Current-sense limit comparator flag |
| ss_trip_i | input | 1 | Soft-start limit comparator flag |
| minon_i | input | 1 | Feedback in the minimum-on band |
| skip_lo_i | input | 1 | Feedback below the skip entry level |
| skip_hi_i | input | 1 | Feedback above the skip exit level |
| drv_o | output | 1 | Gate-drive pulse |
| cyc_start_o | output | 1 | One-clock cycle-start strobe |

## Verification
The hardest state to reach from the ports is a cycle whose length and pulse width depend on the hidden dither phase. Every check of cycle length or duty cap depends on where the triangular sweep stands, and that depends on all the cycles run since reset. The bench therefore keeps its own sweep model from reset onwards, stepping it once at every observed cycle start. It changes the period word only on those boundaries, so that each cycle's expected length and cap are known exactly. Skip hysteresis is brought about in the same way: a sequence of cycles enters skip, holds it with both flags low, and then leaves it.

// File: rtl/pcm_pwm_pkg.sv
package pcm_pwm_pkg;

  typedef enum logic [1:0] {
    END_NONE  = 2'd0,
    END_CAP   = 2'd1,
    END_CMP   = 2'd2,
    END_MINON = 2'd3
  } end_cause_e;

endpackage

// File: rtl/pcm_pwm_dither.sv
module pcm_pwm_dither #(
  parameter int PER_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    step_i,
  input  logic [PER_W-1:0]        per_i,
  output logic signed [PER_W:0]   ofs_o
);

  localparam int PW = PER_W + 6;

  logic [PW-1:0]          prod;
  logic signed [PER_W:0]  lim, d_q, n_raw, a;
  logic                   up_q, up_d;

  function automatic logic signed [PER_W:0] clip(input logic signed [PER_W:0] v,
                                                 input logic signed [PER_W:0] l);
    if (v > l)       return l;
    else if (v < -l) return -l;
    else             return v;
  endfunction

  // about 5% of the period
  assign prod = PW'(per_i) * PW'(51);
  assign lim  = $signed({1'b0, PER_W'(prod >> 10)});
  assign a    = clip(d_q, lim);
  assign ofs_o = a;

  always_comb begin
    up_d = up_q;
    if (up_q) begin
      if (a >= lim) begin
        up_d  = 1'b0;
        n_raw = a - (PER_W+1)'(1);
      end else begin
        n_raw = a + (PER_W+1)'(1);
      end
    end else begin
      if (a <= -lim) begin
        up_d  = 1'b1;
        n_raw = a + (PER_W+1)'(1);
      end else begin
        n_raw = a - (PER_W+1)'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q  <= '0;
      up_q <= 1'b1;
    end else if (step_i) begin
      d_q  <= clip(n_raw, lim);
      up_q <= up_d;
    end
  end

endmodule

// File: rtl/pcm_pwm_osc.sv
module pcm_pwm_osc #(
  parameter int PER_W = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [PER_W-1:0]       per_i,
  input  logic signed [PER_W:0]  ofs_i,
  output logic                   start_o,
  output logic [PER_W:0]         cur_per_o
);

  localparam int CW = PER_W + 1;

  logic [CW-1:0] cnt_q, per_q, per_new, per_now;
  logic          run_q;

  assign per_new   = CW'($signed({1'b0, per_i}) + ofs_i);
  assign start_o   = run_q && (cnt_q == '0);
  assign per_now   = start_o ? per_new : per_q;
  assign cur_per_o = per_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (run_q) begin
        if (start_o) per_q <= per_new;
        cnt_q <= (cnt_q == per_now - 1'b1) ? '0 : cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pcm_pwm_latch.sv
module pcm_pwm_latch
  import pcm_pwm_pkg::*;
#(
  parameter int PER_W      = 12,
  parameter int BLANK_CYC  = 32,
  parameter int MIN_ON_CYC = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [PER_W:0]   cur_per_i,
  input  logic             duty_sel_i,
  input  logic             cs_trip_i,
  input  logic             ss_trip_i,
  input  logic             minon_i,
  input  logic             skip_lo_i,
  input  logic             skip_hi_i,
  output logic             drv_o
);

  localparam int CW = PER_W + 1;
  localparam logic [CW-1:0] BLANK_L = CW'(BLANK_CYC);
  localparam logic [CW-1:0] MINON_L = CW'(MIN_ON_CYC);

  logic [CW+2:0] per_x4;
  logic [CW-1:0] cap, ton_q;
  logic          drv_q, skip_q, skip_nx, mo_q;
  end_cause_e    cause;

  assign per_x4 = {cur_per_i, 2'b00};
  assign cap    = duty_sel_i ? CW'(per_x4 / (CW+3)'(5)) : (cur_per_i >> 1);

  // entry wins over exit; neither holds
  assign skip_nx = skip_lo_i ? 1'b1 : (skip_hi_i ? 1'b0 : skip_q);

  always_comb begin
    cause = END_NONE;
    if (ton_q >= cap) begin
      cause = END_CAP;
    end else if (mo_q) begin
      if (ton_q >= MINON_L) cause = END_MINON;
    end else if (ton_q >= BLANK_L && (cs_trip_i || ss_trip_i)) begin
      cause = END_CMP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_q  <= 1'b0;
      ton_q  <= '0;
      skip_q <= 1'b0;
      mo_q   <= 1'b0;
    end else begin
      if (start_i) begin
        skip_q <= skip_nx;
        mo_q   <= minon_i;
      end
      if (!en_i) begin
        drv_q <= 1'b0;
      end else if (start_i) begin
        drv_q <= !skip_nx;
        ton_q <= CW'(1);
      end else if (drv_q) begin
        if (cause != END_NONE) drv_q <= 1'b0;
        else                   ton_q <= ton_q + 1'b1;
      end
    end
  end

  assign drv_o = drv_q;

endmodule

// File: rtl/pcm_pwm_ctrl.sv
module pcm_pwm_ctrl #(
  parameter int PER_W      = 12,
  parameter int PER_MIN    = 8,
  parameter int BLANK_CYC  = 32,
  parameter int MIN_ON_CYC = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             duty_sel_i,
  input  logic             cs_trip_i,
  input  logic             ss_trip_i,
  input  logic             minon_i,
  input  logic             skip_lo_i,
  input  logic             skip_hi_i,
  output logic             drv_o,
  output logic             cyc_start_o
);

  localparam logic [PER_W-1:0] PER_MIN_L = PER_W'(PER_MIN);

  logic [PER_W-1:0]      per_c;
  logic signed [PER_W:0] dith_ofs;
  logic [PER_W:0]        cur_per;
  logic                  start;

  assign per_c = (period_i < PER_MIN_L) ? PER_MIN_L : period_i;

  pcm_pwm_dither #(.PER_W(PER_W)) u_dith (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (start),
    .per_i  (per_c),
    .ofs_o  (dith_ofs)
  );

  pcm_pwm_osc #(.PER_W(PER_W)) u_osc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .per_i     (per_c),
    .ofs_i     (dith_ofs),
    .start_o   (start),
    .cur_per_o (cur_per)
  );

  pcm_pwm_latch #(
    .PER_W      (PER_W),
    .BLANK_CYC  (BLANK_CYC),
    .MIN_ON_CYC (MIN_ON_CYC)
  ) u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .start_i    (start),
    .cur_per_i  (cur_per),
    .duty_sel_i (duty_sel_i),
    .cs_trip_i  (cs_trip_i),
    .ss_trip_i  (ss_trip_i),
    .minon_i    (minon_i),
    .skip_lo_i  (skip_lo_i),
    .skip_hi_i  (skip_hi_i),
    .drv_o      (drv_o)
  );

  assign cyc_start_o = start;

endmodule

// File: rtl/pcm_pwm_chk.sv
module pcm_pwm_chk #(
  parameter int PER_W = 12
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  en_i,
  input logic                  skip_lo_i,
  input logic                  cyc_start_o,
  input logic                  drv_o,
  input logic signed [PER_W:0] dith_state_i
);

  assert_en_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !drv_o);

  assert_single_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_o |=> !cyc_start_o);

  assert_dither_on_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dith_state_i) |-> $past(cyc_start_o));

  assert_rise_after_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_o) |-> $past(cyc_start_o));

  assert_low_at_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_o |-> !drv_o);

  assert_skip_no_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start_o && skip_lo_i) |=> !drv_o);

endmodule

bind pcm_pwm_ctrl pcm_pwm_chk #(.PER_W(PER_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .skip_lo_i    (skip_lo_i),
  .cyc_start_o  (cyc_start_o),
  .drv_o        (drv_o),
  .dith_state_i (u_dith.d_q)
);

// File: tb/pcm_pwm_ctrl_tb_top.sv
`timescale 1ns/1ps
module pcm_pwm_ctrl_tb_top;

  localparam int PER_W   = 12;
  localparam int PER_MIN = 8;
  localparam int BLANK   = 32;
  localparam int MINON   = 20;

  typedef struct packed {
    int per; int dsel; int cs_at; int ss_at; int mo;
    int slo; int shi; int mid; int en; int ncyc;
  } vec_t;

  localparam int NV = 19;
  //  per  dsel cs  ss  mo slo shi mid en n
  localparam vec_t VEC [NV] = '{
    '{ 200, 0,   0,  0, 0, 0, 0, 0, 1, 4},
    '{ 200, 1,   0,  0, 0, 0, 0, 0, 1, 3},
    '{ 200, 0,  50,  0, 0, 0, 0, 0, 1, 2},
    '{ 200, 0,   5,  0, 0, 0, 0, 0, 1, 2},
    '{ 200, 1,   0, 70, 0, 0, 0, 0, 1, 2},
    '{ 200, 1,   0, 10, 0, 0, 0, 0, 1, 1},
    '{ 200, 0, 150,  0, 0, 0, 0, 0, 1, 1},
    '{ 200, 0,   3,  0, 1, 0, 0, 0, 1, 2},
    '{  30, 0,   0,  0, 1, 0, 0, 0, 1, 2},
    '{ 200, 0,   0,  0, 0, 1, 0, 0, 1, 1},
    '{ 200, 0,   0,  0, 0, 0, 0, 0, 1, 2},
    '{ 200, 0,   0,  0, 0, 0, 1, 0, 1, 1},
    '{ 200, 1,   0,  0, 0, 0, 0, 1, 1, 1},
    '{ 200, 0,   0,  0, 0, 1, 1, 0, 1, 1},
    '{ 200, 0,   0,  0, 0, 0, 1, 0, 1, 1},
    '{ 200, 0,   0,  0, 0, 0, 0, 0, 0, 2},
    '{   4, 0,   0,  0, 0, 0, 0, 0, 1, 2},
    '{1000, 1,   0,  0, 0, 0, 0, 0, 1, 3},
    '{  60, 1,  10,  0, 0, 0, 0, 0, 1, 2}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b1;
  logic [PER_W-1:0] period_i = 12'd200;
  logic duty_sel_i = 1'b0;
  logic cs_trip_i = 1'b0, ss_trip_i = 1'b0, minon_i = 1'b0;
  logic skip_lo_i = 1'b0, skip_hi_i = 1'b0;
  logic drv_o, cyc_start_o;

  int n_chk = 0, n_fail = 0;
  int md = 0, mup = 1, skst = 0;

  always #2.5 clk = ~clk;

  pcm_pwm_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .period_i(period_i),
    .duty_sel_i(duty_sel_i), .cs_trip_i(cs_trip_i), .ss_trip_i(ss_trip_i),
    .minon_i(minon_i), .skip_lo_i(skip_lo_i), .skip_hi_i(skip_hi_i),
    .drv_o(drv_o), .cyc_start_o(cyc_start_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int clipv(int v, int l);
    if (v > l) return l;
    if (v < -l) return -l;
    return v;
  endfunction

  // sweep model per R3; returns cycle length
  function automatic int step_dither(int p);
    int l, a, n;
    l = (p * 51) >> 10;
    a = clipv(md, l);
    if (mup != 0) begin
      if (a >= l) begin mup = 0; n = a - 1; end else n = a + 1;
    end else begin
      if (a <= -l) begin mup = 1; n = a + 1; end else n = a - 1;
    end
    md = clipv(n, l);
    return p + a;
  endfunction

  // called at a negedge where cyc_start_o is seen; returns at the next one
  task automatic run_cycle(input vec_t v);
    int p, peff, m, e, t, tt, len, hi, first;
    string tag, ltag;
    period_i   = PER_W'(v.per);
    duty_sel_i = v.dsel[0];
    minon_i    = v.mo[0];
    skip_lo_i  = v.slo[0];
    skip_hi_i  = v.shi[0];
    en_i       = v.en[0];
    cs_trip_i  = 1'b0;
    ss_trip_i  = 1'b0;
    p    = (v.per < PER_MIN) ? PER_MIN : v.per;
    ltag = (v.per < PER_MIN) ? "R2" : "R3";
    peff = step_dither(p);
    m    = (v.dsel != 0) ? (peff * 4) / 5 : peff / 2;
    if (v.slo != 0) skst = 1; else if (v.shi != 0) skst = 0;
    if (v.en == 0) begin
      e = 0; tag = "R1";
    end else if (skst != 0) begin
      e = 0; tag = (v.slo != 0) ? "R9" : "R10";
    end else if (v.mo != 0) begin
      e = (MINON < m) ? MINON : m; tag = "R8";
    end else begin
      t = v.cs_at;
      if (v.ss_at > 0 && (t == 0 || v.ss_at < t)) t = v.ss_at;
      e = m; tag = "R5";
      if (t > 0) begin
        tt = (t > BLANK) ? t : BLANK;
        if (tt < m) begin e = tt; tag = (t < BLANK) ? "R6" : "R7"; end
      end
    end
    if (v.mid != 0) tag = "R11";
    len = 0; hi = 0; first = 0;
    for (int j = 1; j < 5000; j++) begin
      @(negedge clk);
      len = j;
      if (cyc_start_o) break;
      if (drv_o) begin
        hi++;
        if (first == 0) first = j;
      end
      if (v.cs_at == j) cs_trip_i = 1'b1;
      if (v.ss_at == j) ss_trip_i = 1'b1;
      if (v.mid != 0 && j == 2) skip_lo_i = 1'b1;
    end
    chk(ltag, "cycle length", len, peff);
    chk(tag, "on clocks", hi, e);
    if (e > 0) chk("R4", "first on clock", first, 1);
  endtask

  task automatic wait_start();
    for (int j = 0; j < 5000; j++) begin
      @(negedge clk);
      if (cyc_start_o) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int peff, hi6;
    repeat (3) @(negedge clk);
    chk("R1", "drv in reset", int'(drv_o), 0);
    chk("R1", "strobe in reset", int'(cyc_start_o), 0);
    rst_ni = 1'b1;
    wait_start();

    for (int i = 0; i < NV; i++)
      for (int c = 0; c < VEC[i].ncyc; c++)
        run_cycle(VEC[i]);

    // enable dropped in mid-pulse
    period_i = 12'd200; duty_sel_i = 1'b0; en_i = 1'b1;
    minon_i = 1'b0; skip_lo_i = 1'b0; skip_hi_i = 1'b0;
    cs_trip_i = 1'b0; ss_trip_i = 1'b0;
    peff = step_dither(200);
    hi6 = 0;
    for (int j = 1; j < 5000; j++) begin
      @(negedge clk);
      if (cyc_start_o) begin
        chk("R3", "cycle length after disable", j, peff);
        break;
      end
      if (j == 5) chk("R4", "drv before disable", int'(drv_o), 1);
      if (j == 5) en_i = 1'b0;
      if (j >= 6 && drv_o) hi6++;
    end
    chk("R1", "drv after disable", hi6, 0);
    run_cycle(VEC[0]);

    // reset in mid-run
    repeat (10) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1", "drv after async reset", int'(drv_o), 0);
    chk("R1", "strobe after async reset", int'(cyc_start_o), 0);
    md = 0; mup = 1; skst = 0;
    rst_ni = 1'b1;
    wait_start();
    run_cycle(VEC[1]);
    run_cycle(VEC[0]);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule